// File: doc/BRIEF.md
# Disk Sector DMA Transfer Engine

This engine moves a run of 16-bit words between system memory and a byte-wide disk storage port. A command unit sets up cylinder, track/sector, word count, bus address and the high address bits, then pulses `start`. The engine latches all of it and works out the byte position on the disk. The geometry is fixed at 22 sectors per track, 19 tracks per cylinder and 512-byte sectors. It also forms the physical memory start address. It then streams words one at a time. A disk write reads a word from memory and sends it to storage as two bytes. A disk read collects two bytes from storage and writes them to memory as one word. When the count runs out, `done` pulses and the ready status returns.

The word count is loaded as the two's complement of the number of words. The engine adds one per finished word and ends when the count wraps to zero, so `wc_out` reads zero at completion. Both data ports use valid/ready. On the memory request port and the storage write port, the engine holds valid and its payload steady until ready is seen. On the storage read port, the source must hold a byte until the engine shows ready. A memory read response arrives on `mem_rsp_valid` for one cycle, some time after the request has been accepted. The engine takes it whenever it comes and never pushes back.

Top module: `sector_dma_engine`

## Requirements
- R1: `st_offset` equals ((cyl·19 + track)·22 + sector)·512, with track = `trk_sec[15:8]` and sector = `trk_sec[7:0]`. It is latched at an accepted start and stays constant while busy.
- R2: When `ext_reg` is zero, the first memory address is `bus_addr` with `hi_a16` placed at bit 16 and `hi_a17` placed at bit 17.
- R3: When any bit of `ext_reg` is set, bits 21:16 of the first memory address come from `ext_reg[5:0]`, and `hi_a16`/`hi_a17` have no effect.
- R4: A transfer moves 2^WC_W minus `wc_in` words. A `wc_in` of zero moves 2^WC_W words.
- R5: With `dir_wr`=1, each word read from memory goes out on the storage write port as its bits 7:0 first and then its bits 15:8.
- R6: With `dir_wr`=0, the first storage byte received becomes bits 7:0 and the second becomes bits 15:8 of the word written to memory (`mem_req_write`=1).
- R7: Each later memory request address is the previous word's address plus 2, wrapping within 22 bits.
- R8: `wc_out` goes up by one as each word completes and is zero when `done` is high.
- R9: `done` is a one-cycle pulse in the cycle after the last word completes. In that same cycle `busy` falls and `rdy` rises. `rdy` is 1 after reset and falls when a start is accepted.
- R10: While valid is high and ready is low, the engine keeps `st_wr_valid`/`st_wr_data` and `mem_req_valid`/`mem_addr`/`mem_wdata` steady. No byte or word is lost or repeated under stalls.
- R11: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its count, addresses and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| dir_wr | input | 1 | 1: memory to storage, 0: storage to memory |
| cyl | input | 16 | Desired cylinder |
| trk_sec | input | 16 | Track in 15:8, sector in 7:0 |
| wc_in | input | WC_W (16) | Two's complement of word count |
| bus_addr | input | 16 | Low 16 bits of memory byte address |
| hi_a16 | input | 1 | Address bit 16 when extension is zero |
| hi_a17 | input | 1 | Address bit 17 when extension is zero |
| ext_reg | input | 16 | Address extension; low 6 bits used when nonzero |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdy | output | 1 | Ready status |
| wc_out | output | WC_W (16) | Live word count |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 16 | Read data |
| st_offset | output | 35 | Storage byte offset of the transfer |
| st_wr_valid | output | 1 | Storage write byte valid |
| st_wr_ready | input | 1 | Storage accepts byte |
| st_wr_data | output | 8 | Storage write byte |
| st_rd_valid | input | 1 | Storage read byte valid |
| st_rd_ready | output | 1 | Engine accepts byte |
| st_rd_data | input | 8 | Storage read byte |

## Verification
Two events can coincide. The first is a new `start` landing in the same cycle that `done` is high. The bench launches the next transfer in exactly that cycle, and the reference model requires the new transfer to begin with a fresh count, offset and address while the finished one still reports zero. The second is a `start` arriving in the middle of a transfer. The bench pulses `start` with a different configuration while the port handshakes are stalling at random, and the model requires every later byte, address and count to follow the original transfer. Random ready and valid gaps on all ports make word completion fall in cycles where the other port is stalled.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned SECT_SHIFT = 9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MRD_REQ,
    S_MRD_WAIT,
    S_TX_LO,
    S_TX_HI,
    S_RX_LO,
    S_RX_HI,
    S_MWR_REQ
  } xfer_state_t;
endpackage

// File: rtl/sdma_geom.sv
module sdma_geom #(
  parameter int CYL_W   = 16,
  parameter int TRACKS  = 19,
  parameter int SECTORS = 22,
  parameter int LIN_W   = 26,
  parameter int OFF_W   = 35
) (
  input  logic [CYL_W-1:0] cyl,
  input  logic [15:0]      trk_sec,
  output logic [OFF_W-1:0] byte_off
);
  import sdma_pkg::*;

  logic [LIN_W-1:0] lin;

  always_comb begin
    lin = LIN_W'(cyl) * LIN_W'(TRACKS * SECTORS)
        + LIN_W'(trk_sec[15:8]) * LIN_W'(SECTORS)
        + LIN_W'(trk_sec[7:0]);
    byte_off = {lin, {SECT_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/sdma_phys.sv
module sdma_phys #(
  parameter int EXT_BITS = 6,
  parameter int PA_W     = 22
) (
  input  logic [15:0]     bus_addr,
  input  logic            hi_a16,
  input  logic            hi_a17,
  input  logic [15:0]     ext_reg,
  output logic [PA_W-1:0] phys
);
  logic [EXT_BITS-1:0] legacy_hi;
  logic                use_ext;

  always_comb begin
    legacy_hi = EXT_BITS'({hi_a17, hi_a16});
    use_ext   = |ext_reg;
    phys      = {(use_ext ? ext_reg[EXT_BITS-1:0] : legacy_hi), bus_addr};
  end
endmodule

// File: rtl/sdma_core.sv
module sdma_core #(
  parameter int PA_W = 22,
  parameter int WC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir_wr,
  input  logic [PA_W-1:0] base_addr,
  input  logic [WC_W-1:0] wc_init,
  output logic            busy,
  output logic            done,
  output logic            rdy,
  output logic [WC_W-1:0] wc_out,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [PA_W-1:0] mem_addr,
  output logic [15:0]     mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [15:0]     mem_rsp_data,
  output logic            st_wr_valid,
  input  logic            st_wr_ready,
  output logic [7:0]      st_wr_data,
  input  logic            st_rd_valid,
  output logic            st_rd_ready,
  input  logic [7:0]      st_rd_data
);
  import sdma_pkg::*;

  xfer_state_t     state;
  logic [PA_W-1:0] addr_q;
  logic [WC_W-1:0] wc_q;
  logic [15:0]     word_q;
  logic            done_q;
  logic            rdy_q;

  logic            word_done;
  logic [WC_W-1:0] wc_next;
  logic            last_word;

  always_comb begin
    word_done = (state == S_TX_HI && st_wr_ready) ||
                (state == S_MWR_REQ && mem_req_ready);
    wc_next   = wc_q + WC_W'(1);
    last_word = (wc_next == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      wc_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr_q <= base_addr;
          wc_q   <= wc_init;
          rdy_q  <= 1'b0;
          state  <= dir_wr ? S_MRD_REQ : S_RX_LO;
        end
        S_MRD_REQ:  if (mem_req_ready) state <= S_MRD_WAIT;
        S_MRD_WAIT: if (mem_rsp_valid) begin
          word_q <= mem_rsp_data;
          state  <= S_TX_LO;
        end
        S_TX_LO:    if (st_wr_ready) state <= S_TX_HI;
        S_RX_LO:    if (st_rd_valid) begin
          word_q[7:0] <= st_rd_data;
          state       <= S_RX_HI;
        end
        S_RX_HI:    if (st_rd_valid) begin
          word_q[15:8] <= st_rd_data;
          state        <= S_MWR_REQ;
        end
        default: ;
      endcase
      if (word_done) begin
        wc_q   <= wc_next;
        addr_q <= addr_q + PA_W'(2);
        if (last_word) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          rdy_q  <= 1'b1;
        end else begin
          state <= (state == S_TX_HI) ? S_MRD_REQ : S_RX_LO;
        end
      end
    end
  end

  always_comb begin
    busy          = (state != S_IDLE);
    done          = done_q;
    rdy           = rdy_q;
    wc_out        = wc_q;
    mem_req_valid = (state == S_MRD_REQ) || (state == S_MWR_REQ);
    mem_req_write = (state == S_MWR_REQ);
    mem_addr      = addr_q;
    mem_wdata     = word_q;
    st_wr_valid   = (state == S_TX_LO) || (state == S_TX_HI);
    st_wr_data    = (state == S_TX_HI) ? word_q[15:8] : word_q[7:0];
    st_rd_ready   = (state == S_RX_LO) || (state == S_RX_HI);
  end

  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_valid && !st_wr_ready) |=> (st_wr_valid && $stable(st_wr_data)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_req_write)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wc_out == '0));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdy);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && rdy));
endmodule

// File: rtl/sector_dma_engine.sv
module sector_dma_engine #(
  parameter int CYL_W    = 16,
  parameter int WC_W     = 16,
  parameter int EXT_BITS = 6,
  parameter int TRACKS   = 19,
  parameter int SECTORS  = 22,
  localparam int PA_W    = 16 + EXT_BITS,
  localparam int LIN_W   = CYL_W + $clog2(TRACKS * SECTORS) + 1,
  localparam int OFF_W   = LIN_W + sdma_pkg::SECT_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic [CYL_W-1:0] cyl,
  input  logic [15:0]      trk_sec,
  input  logic [WC_W-1:0]  wc_in,
  input  logic [15:0]      bus_addr,
  input  logic             hi_a16,
  input  logic             hi_a17,
  input  logic [15:0]      ext_reg,
  output logic             busy,
  output logic             done,
  output logic             rdy,
  output logic [WC_W-1:0]  wc_out,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [15:0]      mem_rsp_data,
  output logic [OFF_W-1:0] st_offset,
  output logic             st_wr_valid,
  input  logic             st_wr_ready,
  output logic [7:0]       st_wr_data,
  input  logic             st_rd_valid,
  output logic             st_rd_ready,
  input  logic [7:0]       st_rd_data
);
  logic [OFF_W-1:0] geom_off;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  phys_base;

  sdma_geom #(
    .CYL_W(CYL_W), .TRACKS(TRACKS), .SECTORS(SECTORS),
    .LIN_W(LIN_W), .OFF_W(OFF_W)
  ) u_geom (
    .cyl(cyl), .trk_sec(trk_sec), .byte_off(geom_off)
  );

  sdma_phys #(.EXT_BITS(EXT_BITS), .PA_W(PA_W)) u_phys (
    .bus_addr(bus_addr), .hi_a16(hi_a16), .hi_a17(hi_a17),
    .ext_reg(ext_reg), .phys(phys_base)
  );

  sdma_core #(.PA_W(PA_W), .WC_W(WC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .base_addr(phys_base), .wc_init(wc_in),
    .busy(busy), .done(done), .rdy(rdy), .wc_out(wc_out),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready), .st_wr_data(st_wr_data),
    .st_rd_valid(st_rd_valid), .st_rd_ready(st_rd_ready), .st_rd_data(st_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              off_q <= '0;
    else if (start && !busy) off_q <= geom_off;
  end

  assign st_offset = off_q;

  a_r1_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(st_offset));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> $stable(st_offset));
endmodule

// File: tb/sector_dma_engine_test.sv
`timescale 1ns/1ps
module sector_dma_engine_test;
  localparam int CYLW = 16;
  localparam int WCW  = 6;
  localparam int PAW  = 22;
  localparam int OFFW = 35;
  localparam int WCN  = 1 << WCW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_wr = 1'b0;
  logic [CYLW-1:0] cyl = '0;
  logic [15:0] trk_sec = '0, bus_addr = '0, ext_reg = '0;
  logic [WCW-1:0] wc_in = '0;
  logic hi_a16 = 1'b0, hi_a17 = 1'b0;
  logic busy, done, rdy;
  logic [WCW-1:0] wc_out;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [PAW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic [OFFW-1:0] st_offset;
  logic st_wr_valid, st_rd_ready;
  logic st_wr_ready = 1'b0;
  logic [7:0] st_wr_data;
  logic st_rd_valid = 1'b0;
  logic [7:0] st_rd_data = '0;

  sector_dma_engine #(.CYL_W(CYLW), .WC_W(WCW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .cyl(cyl),
    .trk_sec(trk_sec), .wc_in(wc_in), .bus_addr(bus_addr), .hi_a16(hi_a16),
    .hi_a17(hi_a17), .ext_reg(ext_reg), .busy(busy), .done(done), .rdy(rdy),
    .wc_out(wc_out), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .st_offset(st_offset), .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready),
    .st_wr_data(st_wr_data), .st_rd_valid(st_rd_valid), .st_rd_ready(st_rd_ready),
    .st_rd_data(st_rd_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int pct = 50;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_pat(input longint a);
    return 16'((a * 3) ^ 64'hA55A);
  endfunction

  // reference model state
  bit m_busy, m_done, m_rdy, m_dir, m_ext;
  int m_wc, m_words, m_bytes, m_expect, rx_cnt, pend;
  longint m_base, m_off;
  logic [7:0] rx_lo, rx_hi;
  logic [15:0] pend_data;
  bit hold_wr, hold_mem, rd_taken;
  logic [7:0] hold_wr_byte;
  logic [PAW-1:0] hold_addr;
  logic [15:0] hold_wdata;

  task automatic word_complete();
    m_words++;
    m_bytes = 0;
    m_wc = (m_wc + 1) % WCN;
    if (m_wc == 0) begin
      chk(m_words == m_expect, "R4 word total", m_words, m_expect);
      m_busy = 0; m_done = 1; m_rdy = 1;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rdy = 1; m_wc = 0; pend = 0;
      hold_wr = 0; hold_mem = 0; rd_taken = 0;
      mem_req_ready = 0; st_wr_ready = 0; st_rd_valid = 0; mem_rsp_valid = 0;
    end else begin
      // compare outputs against the model
      chk(busy == m_busy, "R9 busy", busy, m_busy);
      chk(done == m_done, "R9 done", done, m_done);
      chk(rdy == m_rdy, "R9 ready", rdy, m_rdy);
      chk(int'(wc_out) == m_wc, "R8 word count", wc_out, m_wc);
      if (m_busy) chk(st_offset == OFFW'(m_off), "R1 offset", st_offset, m_off);
      if (hold_wr) chk(st_wr_valid && st_wr_data == hold_wr_byte, "R10 storage hold",
                       st_wr_data, hold_wr_byte);
      if (hold_mem) chk(mem_req_valid && mem_addr == hold_addr && mem_wdata == hold_wdata,
                        "R10 memory hold", mem_addr, hold_addr);
      // drive responders for the next edge
      mem_req_ready = ($urandom_range(0, 99) < pct);
      st_wr_ready   = ($urandom_range(0, 99) < pct);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 16'($urandom);
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; end
      end
      if (!(st_rd_valid && !rd_taken)) begin
        st_rd_valid = ($urandom_range(0, 99) < pct);
        st_rd_data  = 8'($urandom);
      end
      // predict the coming edge
      m_done = 0;
      hold_wr = st_wr_valid && !st_wr_ready;
      hold_wr_byte = st_wr_data;
      hold_mem = mem_req_valid && !mem_req_ready;
      hold_addr = mem_addr;
      hold_wdata = mem_wdata;
      if (start && !m_busy) begin
        m_busy = 1; m_rdy = 0; m_dir = dir_wr;
        m_wc = int'(wc_in); m_words = 0; m_bytes = 0; rx_cnt = 0;
        m_expect = (wc_in == 0) ? WCN : WCN - int'(wc_in);
        m_ext = (ext_reg != 0);
        m_base = m_ext ? ((longint'(ext_reg) & 63) << 16) | longint'(bus_addr)
                       : (longint'(hi_a17) << 17) | (longint'(hi_a16) << 16) | longint'(bus_addr);
        m_off = ((longint'(cyl) * 19 + longint'(trk_sec[15:8])) * 22
                 + longint'(trk_sec[7:0])) * 512;
      end
      rd_taken = 0;
      if (st_rd_valid && st_rd_ready) begin
        rd_taken = 1;
        if (rx_cnt == 0) rx_lo = st_rd_data; else rx_hi = st_rd_data;
        rx_cnt ^= 1;
      end
      if (st_wr_valid && st_wr_ready) begin
        logic [15:0] w;
        logic [7:0] eb;
        w = mem_pat((m_base + 2 * m_words) % (1 << PAW));
        eb = (m_bytes == 0) ? w[7:0] : w[15:8];
        chk(m_busy && m_dir && st_wr_data == eb, "R5 storage byte order", st_wr_data, eb);
        m_bytes++;
        if (m_bytes == 2) word_complete();
      end
      if (mem_req_valid && mem_req_ready) begin
        longint ea;
        string tg;
        ea = (m_base + 2 * m_words) % (1 << PAW);
        tg = (m_words == 0) ? (m_ext ? "R3 extended address" : "R2 base address")
                            : "R7 address step";
        chk(longint'(mem_addr) == ea, tg, mem_addr, ea);
        if (mem_req_write) begin
          chk(!m_dir && mem_wdata == {rx_hi, rx_lo}, "R6 word assembly", mem_wdata,
              {rx_hi, rx_lo});
          word_complete();
        end else begin
          chk(m_dir, "R5 read request in write mode", 0, 1);
          pend = 1 + $urandom_range(0, 2);
          pend_data = mem_pat(mem_addr);
        end
      end
    end
  end

  task automatic run_xfer(input bit dw, input logic [15:0] c, input logic [15:0] ts,
                          input int wc, input logic [15:0] ba, input bit a16,
                          input bit a17, input logic [15:0] ex);
    dir_wr = dw; cyl = c; trk_sec = ts; wc_in = WCW'(wc); bus_addr = ba;
    hi_a16 = a16; hi_a17 = a17; ext_reg = ex;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done) begin @(posedge clk); #1; end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    chk(!busy, "R9 reset busy", busy, 0);
    chk(rdy, "R9 reset ready", rdy, 1);
    chk(!done, "R9 reset done", done, 0);
    chk(wc_out == 0, "R8 reset count", wc_out, 0);
    @(posedge clk); #1;
    // disk write, legacy high bits
    run_xfer(1, 16'd3, {8'd2, 8'd5}, WCN - 5, 16'h1000, 1, 0, 16'h0000);
    // back-to-back start in the done cycle: disk read, extension wraps 22 bits
    run_xfer(0, 16'hFFFF, {8'd255, 8'd255}, WCN - 7, 16'hFFFC, 1, 1, 16'h003F);
    // zero count means full range; extension nonzero with zero low bits
    run_xfer(1, 16'd100, {8'd18, 8'd21}, 0, 16'h2000, 1, 1, 16'h0100);
    @(posedge clk); #1;
    // start while busy is ignored (R11)
    dir_wr = 0; cyl = 16'd7; trk_sec = 16'h0102; wc_in = WCW'(WCN - 9);
    bus_addr = 16'h0AB0; hi_a16 = 0; hi_a17 = 1; ext_reg = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (6) @(posedge clk); #1;
    dir_wr = 1; cyl = 16'd9; wc_in = WCW'(WCN - 3); bus_addr = 16'h4000;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (!done) begin @(posedge clk); #1; end
    chk(m_words == 9, "R11 ignored start kept count", m_words, 9);
    // single word with no stalls
    @(posedge clk); #1;
    pct = 100;
    run_xfer(1, 16'd1, {8'd0, 8'd0}, WCN - 1, 16'h0010, 0, 0, 16'h0000);
    pct = 50;
    repeat (3) @(posedge clk); #1;
    chk(!busy && rdy && wc_out == 0, "R8 idle after done", wc_out, 0);
    finish_sim();
  end
endmodule